// File: doc/BRIEF.md
# Run-Time Configurable Minifloat-to-Single-Precision Widener

The block turns 8-bit minifloat bytes into IEEE-754 single-precision words. The byte layout is not fixed. A format register sets four things at run time: whether a sign bit is present, how many bits the exponent field has, how many bits the fraction field has, and the exponent bias. Each tensor can then use the split that suits its range of magnitudes. When the sign bit is absent, the value is taken as nonnegative and the freed bit goes to the exponent or the fraction.

A byte encodes (-1)^s × 2^(e−bias) × (1 + f/2^fw). The widener pulls out the fields and moves the exponent onto the single-precision bias of 127. It places the fraction at the top of the 23-bit mantissa and fills the rest with zeros. The 8-bit format has no subnormals, infinities or NaNs. An exponent that lands outside the normal single-precision range either saturates to the largest finite value or flushes to zero.

Input bytes arrive on a valid/ready stream. Results leave one cycle later on a valid-only stream. A format write that is legal waits until the word in flight has left the output stage, and only then takes effect. While the write is waiting, the input is held off.

Top module: `minifloat_widener`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and cfg_err is 0. The active format is signed, with a 4-bit exponent, a 3-bit fraction and bias 7.
- R2: A byte accepted at a rising edge (in_valid and in_ready both high) produces out_valid high, with its result on out_data, during the following cycle. out_valid is low in every cycle that follows no acceptance.
- R3: The fraction field occupies the lowest fw bits of the byte. The exponent field occupies the ew bits directly above it. When a sign bit is present, it is bit 7. The output has sign s, biased exponent e − bias + 127, and mantissa equal to the fraction shifted left by 23 − fw with zero fill. An exponent field of zero with a nonzero fraction is an ordinary normal value.
- R4: A byte whose exponent and fraction fields are both zero gives a signed zero: 0x00000000, or 0x80000000 when the sign bit is set.
- R5: If e − bias + 127 is above 254, the output is the largest finite value with the byte's sign (0x7F7FFFFF or 0xFF7FFFFF). A result of exactly 254 is passed through unchanged.
- R6: If e − bias + 127 is below 1, the output is a signed zero. A result of exactly 1 is passed through as the smallest normal value.
- R7: With sign width 0, all 8 bits belong to the exponent and fraction fields, and the output sign bit is always 0, even when byte bit 7 is 1.
- R8: A format write is rejected when the sign width is above 1, when the exponent width is 0, or when the three widths do not add up to 8. A rejected write raises cfg_err for exactly the cycle after the write and leaves the active format unchanged.
- R9: A legal format write raises no cfg_err. From the cycle after the write, in_ready stays low until the output stage is empty. The new format then applies. A byte accepted in the same cycle as the write uses the old format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Format write strobe |
| cfg_sign_w | input | 2 | Requested sign-field width (0 or 1 legal) |
| cfg_exp_w | input | 4 | Requested exponent-field width |
| cfg_frac_w | input | 4 | Requested fraction-field width |
| cfg_bias | input | 8 | Requested exponent bias (unsigned) |
| cfg_err | output | 1 | One-cycle pulse: last format write rejected |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte may be accepted |
| in_data | input | 8 | Minifloat byte |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Single-precision result |

## Verification
The bench targets the edges of the exponent window. It checks a rebiased exponent of exactly 254 and one just above it, and exactly 1 and one just below it. A design with an off-by-one compare would saturate or flush a value that should pass, or emit an exponent of all ones. The unsigned layout is driven with bit 7 set: a design that still reads a sign would return negative results there. Three kinds of illegal write are each followed by a byte decoded under the old format, which catches a design that commits a bad format. The bench also places a format write in the same cycle as an accepted byte. A design that switches format too early would decode that byte with the new layout, and one that does not stall would let a byte slip through during the change.

// File: rtl/mfw_pkg.sv
package mfw_pkg;
   localparam int unsigned IN_W      = 8;
   localparam int unsigned FP_EXP_W  = 8;
   localparam int unsigned FP_MAN_W  = 23;
   localparam int unsigned FP_BIAS   = (1 << (FP_EXP_W - 1)) - 1;
   localparam int unsigned WID_W     = $clog2(IN_W + 1);
   localparam int unsigned BIAS_W    = IN_W;

   typedef struct packed {
      logic                signed_fmt;
      logic [WID_W-1:0]    exp_w;
      logic [WID_W-1:0]    frac_w;
      logic [BIAS_W-1:0]   bias;
   } fmt_t;

   localparam fmt_t FMT_RESET = '{signed_fmt: 1'b1,
                                  exp_w:      WID_W'(4),
                                  frac_w:     WID_W'(3),
                                  bias:       BIAS_W'(7)};
endpackage

// File: rtl/mfw_fmt_reg.sv
module mfw_fmt_reg
   import mfw_pkg::*;
#(
   parameter int unsigned W_IN = IN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sign_w,
   input  logic [WID_W-1:0] wr_exp_w,
   input  logic [WID_W-1:0] wr_frac_w,
   input  logic [BIAS_W-1:0] wr_bias,
   input  logic             stage_busy,
   output fmt_t             fmt_now,
   output logic             hold_in,
   output logic             wr_reject
);
   localparam int unsigned SUM_W = WID_W + 2;

   logic [SUM_W-1:0] width_sum;
   logic             legal;
   fmt_t             pend_fmt;
   logic             pend_q;

   assign width_sum = SUM_W'(wr_sign_w) + SUM_W'(wr_exp_w) + SUM_W'(wr_frac_w);
   assign legal     = (wr_sign_w <= 2'd1) && (wr_exp_w != '0)
                      && (width_sum == SUM_W'(W_IN));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_now   <= FMT_RESET;
         pend_fmt  <= FMT_RESET;
         pend_q    <= 1'b0;
         wr_reject <= 1'b0;
      end else begin
         wr_reject <= wr_en && !legal;
         if (wr_en && legal) begin
            pend_fmt <= '{signed_fmt: wr_sign_w[0], exp_w: wr_exp_w,
                          frac_w: wr_frac_w, bias: wr_bias};
            pend_q   <= 1'b1;
         end else if (pend_q && !stage_busy) begin
            fmt_now <= pend_fmt;
            pend_q  <= 1'b0;
         end
      end
   end

   assign hold_in = pend_q;
endmodule

// File: rtl/mfw_field_split.sv
module mfw_field_split
   import mfw_pkg::*;
#(
   parameter int unsigned W_IN = IN_W
) (
   input  logic [W_IN-1:0] byte_in,
   input  fmt_t            fmt,
   output logic            sgn,
   output logic [W_IN-1:0] exp_fld,
   output logic [W_IN-1:0] frac_fld
);
   logic [W_IN-1:0] above_frac;

   assign above_frac = byte_in >> fmt.frac_w;
   assign sgn        = fmt.signed_fmt & byte_in[W_IN-1];

   for (genvar i = 0; i < W_IN; i++) begin : g_mask
      assign frac_fld[i] = (WID_W'(i) < fmt.frac_w) ? byte_in[i]    : 1'b0;
      assign exp_fld[i]  = (WID_W'(i) < fmt.exp_w)  ? above_frac[i] : 1'b0;
   end
endmodule

// File: rtl/mfw_rebias.sv
module mfw_rebias
   import mfw_pkg::*;
#(
   parameter int unsigned W_IN  = IN_W,
   parameter int unsigned EXP_W = FP_EXP_W,
   parameter int unsigned MAN_W = FP_MAN_W
) (
   input  logic                   sgn,
   input  logic [W_IN-1:0]        exp_fld,
   input  logic [W_IN-1:0]        frac_fld,
   input  logic [WID_W-1:0]       frac_w,
   input  logic [BIAS_W-1:0]      bias,
   output logic [EXP_W+MAN_W:0]   word
);
   localparam int unsigned CW      = W_IN + EXP_W + 2;
   localparam int unsigned OUT_BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int unsigned EXP_TOP  = (1 << EXP_W) - 2;

   logic [CW-1:0]    lifted;
   logic [CW-1:0]    bias_w;
   logic [CW-1:0]    new_exp;
   logic [MAN_W-1:0] man;
   logic             is_zero, under, over;

   assign lifted  = CW'(exp_fld) + CW'(OUT_BIAS);
   assign bias_w  = CW'(bias);
   assign new_exp = lifted - bias_w;
   assign is_zero = (exp_fld == '0) && (frac_fld == '0);
   assign under   = (lifted <= bias_w);
   assign over    = !under && (new_exp > CW'(EXP_TOP));
   assign man     = MAN_W'(frac_fld) << (MAN_W - int'(frac_w));

   always_comb begin
      if (is_zero || under)
         word = {sgn, {(EXP_W + MAN_W){1'b0}}};
      else if (over)
         word = {sgn, EXP_W'(EXP_TOP), {MAN_W{1'b1}}};
      else
         word = {sgn, new_exp[EXP_W-1:0], man};
   end
endmodule

// File: rtl/minifloat_widener.sv
module minifloat_widener
   import mfw_pkg::*;
#(
   parameter int unsigned W_IN  = IN_W,
   parameter int unsigned EXP_W = FP_EXP_W,
   parameter int unsigned MAN_W = FP_MAN_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_sign_w,
   input  logic [3:0]           cfg_exp_w,
   input  logic [3:0]           cfg_frac_w,
   input  logic [7:0]           cfg_bias,
   output logic                 cfg_err,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [7:0]           in_data,
   output logic                 out_valid,
   output logic [31:0]          out_data
);
   localparam int unsigned OUT_W = EXP_W + MAN_W + 1;

   if (W_IN != IN_W) begin : g_bad_in
      $error("minifloat_widener: W_IN must match the package byte width");
   end
   if (W_IN > MAN_W + 1) begin : g_bad_man
      $error("minifloat_widener: fraction cannot fit the mantissa");
   end
   if (OUT_W != 32) begin : g_bad_out
      $error("minifloat_widener: output must be 32 bits");
   end

   fmt_t             fmt;
   logic             hold;
   logic             accept;
   logic             sgn;
   logic [W_IN-1:0]  exp_fld, frac_fld;
   logic [OUT_W-1:0] conv;

   assign in_ready = !hold;
   assign accept   = in_valid && in_ready;

   mfw_fmt_reg #(.W_IN(W_IN)) u_fmt (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we),
      .wr_sign_w(cfg_sign_w), .wr_exp_w(cfg_exp_w), .wr_frac_w(cfg_frac_w),
      .wr_bias(cfg_bias), .stage_busy(out_valid),
      .fmt_now(fmt), .hold_in(hold), .wr_reject(cfg_err)
   );

   mfw_field_split #(.W_IN(W_IN)) u_split (
      .byte_in(in_data), .fmt(fmt),
      .sgn(sgn), .exp_fld(exp_fld), .frac_fld(frac_fld)
   );

   mfw_rebias #(.W_IN(W_IN), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_rebias (
      .sgn(sgn), .exp_fld(exp_fld), .frac_fld(frac_fld),
      .frac_w(fmt.frac_w), .bias(fmt.bias), .word(conv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= accept;
         if (accept) out_data <= conv;
      end
   end
endmodule

// File: rtl/mfw_checker.sv
module mfw_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_we,
   input logic        cfg_err,
   input logic        in_valid,
   input logic        in_ready,
   input logic [7:0]  in_data,
   input logic        out_valid,
   input logic [31:0] out_data
);
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) |=> !out_valid);

   a_r4_zero_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_data == 8'h00) |=> (out_data[30:0] == 31'd0));

   a_r5_no_inf_exp: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[30:23] != 8'hFF));

   a_r8_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> !cfg_err);
endmodule

bind minifloat_widener mfw_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_err(cfg_err),
   .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
   .out_valid(out_valid), .out_data(out_data)
);

// File: tb/minifloat_widener_tb.sv
module minifloat_widener_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sign_w = '0;
   logic [3:0]  cfg_exp_w = '0;
   logic [3:0]  cfg_frac_w = '0;
   logic [7:0]  cfg_bias = '0;
   logic        cfg_err;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        out_valid;
   logic [31:0] out_data;

   int tests = 0;
   int fails = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   minifloat_widener u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sign_w(cfg_sign_w),
      .cfg_exp_w(cfg_exp_w), .cfg_frac_w(cfg_frac_w), .cfg_bias(cfg_bias),
      .cfg_err(cfg_err), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      tests++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, expv);
      end
   endtask

   // monitor: scoreboard pop and compare
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R2 unexpected output", out_data, 32'hxxxxxxxx);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, out_data, e);
         end
      end
   end

   // called at a negedge; returns at the negedge after acceptance
   task automatic send(input logic [7:0] b, input logic [31:0] expv, input string tag);
      in_data  = b;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      exp_q.push_back(expv);
      tag_q.push_back(tag);
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R2 valid next cycle"}, {31'd0, out_valid}, 32'd1);
   endtask

   task automatic cfg(input logic [1:0] s, input logic [3:0] e, input logic [3:0] f,
                      input logic [7:0] b, input logic bad, input string tag);
      cfg_sign_w = s; cfg_exp_w = e; cfg_frac_w = f; cfg_bias = b; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      check({tag, " cfg_err"}, {31'd0, cfg_err}, {31'd0, bad});
      @(negedge clk);
      check({tag, " cfg_err clears"}, {31'd0, cfg_err}, 32'd0);
      while (!in_ready) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 out_valid", {31'd0, out_valid}, 32'd0);
      check("R1 in_ready", {31'd0, in_ready}, 32'd1);
      check("R1 cfg_err", {31'd0, cfg_err}, 32'd0);

      // R1/R3 default 1/4/3 bias 7
      send(8'h38, 32'h3F800000, "R1 default one");
      send(8'hC5, 32'hC0500000, "R3 negative normal");
      send(8'h7F, 32'h43F00000, "R3 largest default");
      send(8'h01, 32'h3C100000, "R3 zero exp nonzero frac");
      send(8'h80, 32'h80000000, "R4 negative zero");
      send(8'h00, 32'h00000000, "R4 positive zero");
      @(negedge clk);
      check("R2 idle no valid", {31'd0, out_valid}, 32'd0);

      // R8 illegal writes, old format kept
      cfg(2'd2, 4'd3, 4'd3, 8'd0, 1'b1, "R8 sign width 2");
      send(8'h38, 32'h3F800000, "R8 format kept a");
      cfg(2'd1, 4'd4, 4'd4, 8'd0, 1'b1, "R8 sum nine");
      send(8'h38, 32'h3F800000, "R8 format kept b");
      cfg(2'd1, 4'd0, 4'd7, 8'd0, 1'b1, "R8 zero exp width");
      send(8'h38, 32'h3F800000, "R8 format kept c");

      // R7 unsigned 0/5/3 bias 15
      cfg(2'd0, 4'd5, 4'd3, 8'd15, 1'b0, "R9 legal unsigned");
      send(8'hFF, 32'h47F00000, "R7 bit7 not sign");
      send(8'h80, 32'h40000000, "R7 exponent uses bit7");

      // R5 saturation 0/8/0 bias 0
      cfg(2'd0, 4'd8, 4'd0, 8'd0, 1'b0, "R9 legal exp only");
      send(8'h7F, 32'h7F000000, "R5 exponent 254 passes");
      send(8'h80, 32'h7F7FFFFF, "R5 exponent 255 saturates");
      send(8'hC8, 32'h7F7FFFFF, "R5 far overflow");

      // R6 underflow 1/4/3 bias 140
      cfg(2'd1, 4'd4, 4'd3, 8'd140, 1'b0, "R9 legal high bias");
      send(8'h70, 32'h00800000, "R6 exponent 1 passes");
      send(8'hE8, 32'h80000000, "R6 exponent 0 flushes");
      send(8'hC5, 32'hF0D8F8C9 & 32'h0 | 32'h80000000, "R6 deep underflow");

      // R5 negative saturation: 1/7/0 bias 0, byte 0xFF -> e=127 -> 254 passes; use e>127
      cfg(2'd1, 4'd7, 4'd0, 8'd0, 1'b0, "R9 legal 1/7/0");
      send(8'hFF, 32'hFF000000, "R5 negative at 254");

      // R9 write in the same cycle as an accepted byte
      cfg(2'd1, 4'd4, 4'd3, 8'd7, 1'b0, "R9 back to default");
      in_data    = 8'h38;
      in_valid   = 1'b1;
      cfg_sign_w = 2'd0; cfg_exp_w = 4'd4; cfg_frac_w = 4'd4; cfg_bias = 8'd7;
      cfg_we     = 1'b1;
      exp_q.push_back(32'h3F800000);
      tag_q.push_back("R9 old format for concurrent byte");
      @(negedge clk);
      in_valid = 1'b0;
      cfg_we   = 1'b0;
      check("R9 stall after write", {31'd0, in_ready}, 32'd0);
      check("R9 no err on legal write", {31'd0, cfg_err}, 32'd0);
      // 0/4/4 bias 7: 0x38 -> e=3 f=8 -> exp 123, man 0x400000
      send(8'h38, 32'h3DC00000, "R9 new format applies");

      repeat (3) @(negedge clk);
      check("R2 queue drained", exp_q.size(), 32'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule